// File: doc/BRIEF.md
# Early-Exit Sequential Shift-Add Multiplier

The block multiplies two unsigned operands with one adder. It handles one multiplier bit per clock. Pulsing `start` while the block is idle loads both operands and clears the accumulated result. The block then repeats one step each cycle:

- The current multiplicand is ANDed with a mask copied from the multiplier's lowest bit, and that masked value is always added into the result.
- The multiplier shifts right by one place.
- The multiplicand shifts left by one place.

The run stops the moment the remaining multiplier reaches zero. A run therefore lasts as many steps as the multiplier has significant bits. A zero multiplier finishes without taking any step.

The result is kept at the operand width. Carries past the top bit and multiplicand bits shifted out at the top are dropped, so the result is the product modulo 2^W. The controller has three states:

- **IDLE**: waits for `start`. An accepted start with a zero multiplier goes to **FIN**; any other accepted start goes to **RUN**.
- **RUN**: takes one step per cycle. It goes to **FIN** on the step that empties the multiplier.
- **FIN**: asserts `done` for one cycle, then always returns to **IDLE**.

Top module: `shiftadd_mul`

## Requirements
- R1: When `start` is high at a rising edge while `busy` is low, the operands are captured, `result` reads zero after that edge, and `busy` is high after that edge.
- R2: In the cycle where `done` is high, `result` equals (`op_a` × `op_b`) mod 2^W, using the operands captured at acceptance.
- R3: Let n be one plus the index of the highest set bit of the captured `op_b`, with n = 0 when `op_b` is zero. `done` is high in the cycle that begins n rising edges after the accepting edge. For n = 0, that is the cycle right after the accepting edge.
- R4: `done` is high for exactly one cycle per run. `busy` is high from the accepting edge through the `done` cycle inclusive, and is low in the cycle after `done`.
- R5: A `start` seen while `busy` is high is ignored. The operands are not reloaded, and the run completes with its original latency and product.
- R6: While `busy` is low, `result` holds its value until the next accepted start, even if the operands change.
- R7: During and directly after reset, `busy` = 0, `done` = 0 and `result` = 0.
- R8: Latency depends only on `op_b`. With `op_a` = 0 the run still takes n steps and yields 0. Multiplicand bits shifted past the top bit are lost, so for example 0x80000000 × 3 gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (taken only when idle) |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier; its bit length sets the latency |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Low W bits of the product; held while idle |

## Verification
A 6-bit copy is swept over every operand pair. It checks each product and each data-dependent latency, including the zero-multiplier case that must finish with no steps. A wrong stop test would show up as a latency that is one cycle off, or as a zero-multiplier run that takes a step. A 32-bit copy covers:

- the all-ones operands;
- multiplicand overflow, where a design that kept shifted-out bits would give a wrong low half;
- a zero multiplicand with a top-bit multiplier, which must still take 32 steps.

A start pulse in the middle of a run and operand changes while idle target designs that reload while busy or let `result` drift before the next accepted start.

// File: rtl/sam_pkg.sv
package sam_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sam_state_t;
endpackage

// File: rtl/sam_step.sv
module sam_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W-1:0] acc_nxt,
    output logic [W-1:0] mcand_nxt,
    output logic [W-1:0] mplier_nxt,
    output logic         last
);
    logic [W-1:0] masked;

    // branch-free select: each multiplicand bit gated by the multiplier LSB
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign masked[i] = mcand[i] & mplier[0];
    end

    assign acc_nxt    = acc + masked;
    assign mcand_nxt  = {mcand[W-2:0], 1'b0};
    assign mplier_nxt = {1'b0, mplier[W-1:1]};
    assign last       = (mplier[W-1:1] == '0);
endmodule

// File: rtl/sam_dpath.sv
module sam_dpath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step_en,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] acc,
    output logic         step_last,
    output logic         mpl_zero
);
    logic [W-1:0] mcand, mplier;
    logic [W-1:0] acc_nxt, mcand_nxt, mplier_nxt;

    sam_step #(.W(W)) u_step (
        .acc        (acc),
        .mcand      (mcand),
        .mplier     (mplier),
        .acc_nxt    (acc_nxt),
        .mcand_nxt  (mcand_nxt),
        .mplier_nxt (mplier_nxt),
        .last       (step_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
        end else if (load) begin
            acc    <= '0;
            mcand  <= op_a;
            mplier <= op_b;
        end else if (step_en) begin
            acc    <= acc_nxt;
            mcand  <= mcand_nxt;
            mplier <= mplier_nxt;
        end
    end

    assign mpl_zero = (mplier == '0);

    // R5
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> ($stable(mplier) && $stable(mcand) && $stable(acc)));
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
    import sam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic opb_zero,
    input  logic step_last,
    input  logic mpl_zero,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);
    sam_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = opb_zero ? ST_FIN : ST_RUN;
            ST_RUN:  if (step_last) state_nxt = ST_FIN;
            ST_FIN:  state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: load = start;
            ST_RUN:  begin busy = 1'b1; step_en = 1'b1; end
            ST_FIN:  begin busy = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R3
    fin_exhausted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mpl_zero);
    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] ZERO = '0;

    logic load, step_en, step_last, mpl_zero, opb_zero;

    assign opb_zero = (op_b == ZERO);

    sam_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opb_zero  (opb_zero),
        .step_last (step_last),
        .mpl_zero  (mpl_zero),
        .load      (load),
        .step_en   (step_en),
        .busy      (busy),
        .done      (done)
    );

    sam_dpath #(.W(W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step_en   (step_en),
        .op_a      (op_a),
        .op_b      (op_b),
        .acc       (result),
        .step_last (step_last),
        .mpl_zero  (mpl_zero)
    );

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
    // R1
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (result == ZERO));
endmodule

// File: tb/sim_shiftadd_mul.sv
module sim_shiftadd_mul;
    localparam int WS = 6;
    localparam int WL = 32;
    localparam int NS = 1 << WS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start0 = 1'b0, start1 = 1'b0;
    logic [WS-1:0] a0 = '0, b0 = '0;
    logic [WL-1:0] a1 = '0, b1 = '0;
    logic          busy0, done0, busy1, done1;
    logic [WS-1:0] result0;
    logic [WL-1:0] result1;

    int errors = 0;
    int checks = 0;

    shiftadd_mul #(.W(WS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start0), .op_a(a0), .op_b(b0),
        .busy(busy0), .done(done0), .result(result0)
    );

    shiftadd_mul #(.W(WL)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .op_a(a1), .op_b(b1),
        .busy(busy1), .done(done1), .result(result1)
    );

    function automatic int bitlen(input logic [WL-1:0] v);
        int n = 0;
        for (int i = 0; i < WL; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_small(input int a, input int b);
        int n;
        logic [WS-1:0] prod;
        prod = WS'(a * b);
        @(negedge clk);
        a0 = WS'(a); b0 = WS'(b); start0 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start0 = 1'b0;
        check(busy0 == 1'b1, "R1 busy after accept", busy0, 1);
        if (b != 0) check(result0 == '0, "R1 result cleared", result0, 0);
        n = 0;
        while (!done0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == bitlen(WL'(b)), "R3 latency", n, bitlen(WL'(b)));
        check(result0 == prod, "R2 product", result0, prod);
        a0 = ~a0; b0 = ~b0;
        @(negedge clk);
        check(!done0 && !busy0, "R4 done single busy low", {done0, busy0}, 0);
        check(result0 == prod, "R6 result held", result0, prod);
    endtask

    task automatic run_large(input logic [WL-1:0] a, input logic [WL-1:0] b,
                             input bit poke, input string req);
        int n;
        logic [WL-1:0] prod;
        prod = a * b;
        @(negedge clk);
        a1 = a; b1 = b; start1 = 1'b1;
        @(negedge clk);
        start1 = 1'b0;
        n = 0;
        while (!done1 && n < 100) begin
            if (poke && n == 2) begin
                a1 = 32'h5; b1 = 32'h0; start1 = 1'b1;   // R5 start while busy
            end else begin
                start1 = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start1 = 1'b0;
        check(n == bitlen(b), {req, " latency"}, n, bitlen(b));
        check(result1 == prod, {req, " product"}, result1, prod);
        a1 = 32'h1234_5678; b1 = 32'h9;
        repeat (4) @(negedge clk);
        check(!busy1 && result1 == prod, "R6 hold after operand change", result1, prod);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset values while in reset
        check(!busy0 && !done0 && result0 == '0, "R7 reset u0", {busy0, done0, result0}, 0);
        check(!busy1 && !done1 && result1 == '0, "R7 reset u1", {busy1, done1}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy0 && result0 == '0, "R7 after reset", result0, 0);

        // R2 R3 exhaustive sweep of the small instance
        for (int a = 0; a < NS; a++)
            for (int b = 0; b < NS; b++)
                run_small(a, b);

        run_large(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2 all ones");
        run_large(32'h8000_0000, 32'h3, 1'b0, "R8 overflow discard");
        run_large(32'h0, 32'h8000_0000, 1'b0, "R8 zero multiplicand");
        run_large(32'h0001_2345, 32'h0, 1'b0, "R3 zero multiplier");
        run_large(32'hDEAD_BEEF, 32'h10, 1'b0, "R2 power of two");
        run_large(32'h0003_0001, 32'h8000_0001, 1'b1, "R5 ignored start");
        run_large(32'h7, 32'h1, 1'b0, "R3 single step");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule